// File: doc/BRIEF.md
# Packed Lane Narrowing and Interleaving Unit

This block converts packed 64-bit data between lane widths. It has two kinds of operation. A pack takes two source operands and narrows every lane of both to half width, saturating any value that does not fit. The narrowing either treats the result lanes as signed or as unsigned. An unpack takes the lanes from one half (upper or lower) of each operand and weaves them together, alternating between the two operands, into a full 64-bit result.

A two-bit operation code picks the operation and a one-bit size code picks the lane pairing. The pairings are 16-bit sources narrowed to 8-bit lanes, or 32-bit sources narrowed to 16-bit lanes. The result is meant to be written back over the first operand by the surrounding datapath. All conversion logic is combinational. A single output register gives a fixed latency of one cycle, and a new operation can be issued on every clock.

Top module: `pkconv_unit`

## Requirements
- R1: `result` is registered. It shows the conversion of the `op`, `sz`, `src_a` and `src_b` sampled at the previous rising clock edge. A new operation is accepted on every cycle, and each result depends only on its own inputs.
- R2: While `rst_n` is low, `result` is 0. The reset is asynchronous and active low.
- R3: With `op` = 2'b00 (signed-saturating pack), each source lane is read as a two's-complement number. It is clamped to the signed range of the narrow lane: -128..127 for 8-bit lanes and -32768..32767 for 16-bit lanes. A value already in range is copied unchanged.
- R4: With `op` = 2'b01 (unsigned-saturating pack), each source lane is read as a two's-complement number. A negative value gives 0. A value above the narrow unsigned maximum gives all ones (0xFF or 0xFFFF). Any other value is copied unchanged.
- R5: For both packs, the narrowed lanes of `src_a` fill the lower 32 bits of `result` and those of `src_b` fill the upper 32 bits. Lane order is kept, so source lane k of `src_a` lands in result lane k.
- R6: With `op` = 2'b11 (low unpack), result lane 2k holds `src_a` lane k and result lane 2k+1 holds `src_b` lane k, for every lane k in the lower 32 bits.
- R7: With `op` = 2'b10 (high unpack), result lane 2k holds `src_a` lane H+k and result lane 2k+1 holds `src_b` lane H+k. Here H is the number of lanes in 32 bits, so the lanes come from the upper 32 bits of each operand.
- R8: `sz` = 0 selects 16-bit source lanes and 8-bit result lanes for pack, and 8-bit lanes for unpack. `sz` = 1 selects 32-bit source lanes and 16-bit result lanes for pack, and 16-bit lanes for unpack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 2 | Operation: 00 signed pack, 01 unsigned pack, 10 high unpack, 11 low unpack |
| sz | input | 1 | Lane pairing: 0 is 16 to 8 bits, 1 is 32 to 16 bits |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| result | output | 64 | Registered conversion result |

## Verification
In one signed or unsigned pack, clamping to the upper bound, clamping to the lower bound and plain copying can all happen at the same time. They can also be split across lanes from `src_a` and from `src_b`, which end up in different halves of the result. Directed vectors place in-range, just-too-large and just-too-small values in lanes of both operands together. Random operands, operation codes and sizes then keep mixing these cases, and the operation and size also change from one cycle to the next. Every result is compared lane by lane against a behavioural model in the bench. The model finds the bounds from integer arithmetic rather than from bit patterns.

// File: rtl/pkconv_pkg.sv
package pkconv_pkg;
  typedef enum logic [1:0] {
    PK_SSAT = 2'b00,
    PK_USAT = 2'b01,
    UNPK_HI = 2'b10,
    UNPK_LO = 2'b11
  } pkconv_op_e;

  typedef enum logic {
    SZ_NARROW8  = 1'b0,
    SZ_NARROW16 = 1'b1
  } pkconv_sz_e;
endpackage

// File: rtl/pkconv_pack.sv
module pkconv_pack #(
  parameter int DW = 64,
  parameter int NW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          usat,
  output logic [DW-1:0] y
);
  localparam int WW = 2 * NW;
  localparam int N  = DW / WW;

  // Clamp one wide lane into NW bits, signed or unsigned target.
  function automatic logic [NW-1:0] narrow(input logic [WW-1:0] v, input logic uns);
    logic neg, sfit, ufit;
    neg  = v[WW-1];
    sfit = (v[WW-1:NW-1] == {(NW+1){v[WW-1]}});
    ufit = (v[WW-1:NW] == '0);
    if (uns) begin
      if (neg)       narrow = '0;
      else if (ufit) narrow = v[NW-1:0];
      else           narrow = '1;
    end else begin
      if (sfit)      narrow = v[NW-1:0];
      else if (neg)  narrow = {1'b1, {(NW-1){1'b0}}};
      else           narrow = {1'b0, {(NW-1){1'b1}}};
    end
  endfunction

  for (genvar g = 0; g < 2 * N; g++) begin : g_lane
    if (g < N) begin : g_from_a
      assign y[g*NW +: NW] = narrow(a[g*WW +: WW], usat);
    end else begin : g_from_b
      assign y[g*NW +: NW] = narrow(b[(g-N)*WW +: WW], usat);
    end
  end
endmodule

// File: rtl/pkconv_unpack.sv
module pkconv_unpack #(
  parameter int DW = 64,
  parameter int NW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          hi,
  output logic [DW-1:0] y
);
  localparam int H = DW / (2 * NW);

  for (genvar k = 0; k < H; k++) begin : g_pair
    assign y[(2*k)*NW   +: NW] = hi ? a[(H+k)*NW +: NW] : a[k*NW +: NW];
    assign y[(2*k+1)*NW +: NW] = hi ? b[(H+k)*NW +: NW] : b[k*NW +: NW];
  end
endmodule

// File: rtl/pkconv_unit.sv
module pkconv_unit #(
  parameter int DW     = 64,
  parameter int BYTE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op,
  input  logic          sz,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic [DW-1:0] result
);
  import pkconv_pkg::*;

  localparam int HALF_W = 2 * BYTE_W;

  pkconv_op_e  op_e;
  pkconv_sz_e  sz_e;
  logic [DW-1:0] pack_nb, pack_nh, unpk_nb, unpk_nh;
  logic [DW-1:0] conv_nxt;
  logic          is_usat, is_hi;

  assign op_e    = pkconv_op_e'(op);
  assign sz_e    = pkconv_sz_e'(sz);
  assign is_usat = (op_e == PK_USAT);
  assign is_hi   = (op_e == UNPK_HI);

  pkconv_pack #(.DW(DW), .NW(BYTE_W)) u_pack_b (
    .a(src_a), .b(src_b), .usat(is_usat), .y(pack_nb));
  pkconv_pack #(.DW(DW), .NW(HALF_W)) u_pack_h (
    .a(src_a), .b(src_b), .usat(is_usat), .y(pack_nh));
  pkconv_unpack #(.DW(DW), .NW(BYTE_W)) u_unpk_b (
    .a(src_a), .b(src_b), .hi(is_hi), .y(unpk_nb));
  pkconv_unpack #(.DW(DW), .NW(HALF_W)) u_unpk_h (
    .a(src_a), .b(src_b), .hi(is_hi), .y(unpk_nh));

  always_comb begin
    unique case (op_e)
      PK_SSAT, PK_USAT: conv_nxt = (sz_e == SZ_NARROW16) ? pack_nh : pack_nb;
      default:          conv_nxt = (sz_e == SZ_NARROW16) ? unpk_nh : unpk_nb;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= conv_nxt;
  end
endmodule

// File: rtl/pkconv_unit_chk.sv
module pkconv_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    op,
  input logic          sz,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic [DW-1:0] result
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  a_r2_reset_zero: assert property (@(posedge clk) !rst_n |-> result == '0);

  a_r6_low_base_lane: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op) == 2'b11 |-> result[7:0] == $past(src_a[7:0]));

  a_r7_high_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op) == 2'b10 |-> result[DW-1:DW-8] == $past(src_b[DW-1:DW-8]));

  a_r3_clamp_positive: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op == 2'b00 && !sz && !src_a[15] && src_a[14:7] != 8'h00)
    |-> result[7:0] == 8'h7f);

  a_r4_negative_floor: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op == 2'b01 && !sz && src_b[15]) |-> result[39:32] == 8'h00);

  a_r5_a_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(op == 2'b01 && sz && src_a[31:16] == 16'h0000)
    |-> result[15:0] == $past(src_a[15:0]));
endmodule

bind pkconv_unit pkconv_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .sz(sz),
  .src_a(src_a), .src_b(src_b), .result(result));

// File: tb/sim_pkconv_unit.sv
`timescale 1ns/1ps
module sim_pkconv_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op;
  logic        sz;
  logic [63:0] src_a, src_b;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  pkconv_unit u0 (.clk(clk), .rst_n(rst_n), .op(op), .sz(sz),
                  .src_a(src_a), .src_b(src_b), .result(result));

  // Behavioural model: integer arithmetic per lane.
  function automatic logic [63:0] model(logic [1:0] o, logic s, logic [63:0] a, logic [63:0] b);
    int nw, ww, n, h, base;
    longint v, lo, hi;
    logic [63:0] r, src, nmask, wmask;
    nw = s ? 16 : 8;
    ww = 2 * nw;
    n  = 64 / ww;
    h  = 64 / (2 * nw);
    r  = '0;
    nmask = (64'd1 << nw) - 1;
    wmask = (64'd1 << ww) - 1;
    if (o < 2) begin
      for (int i = 0; i < 2 * n; i++) begin
        src = (i < n) ? a : b;
        v = longint'((src >> ((i % n) * ww)) & wmask);
        if (v >= (longint'(1) << (ww - 1))) v -= (longint'(1) << ww);
        if (o == 0) begin lo = -(longint'(1) << (nw - 1)); hi = (longint'(1) << (nw - 1)) - 1; end
        else        begin lo = 0; hi = (longint'(1) << nw) - 1; end
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        r |= (64'(v) & nmask) << (i * nw);
      end
    end else begin
      base = (o == 2) ? h : 0;
      for (int k = 0; k < h; k++) begin
        r |= ((a >> ((base + k) * nw)) & nmask) << ((2 * k) * nw);
        r |= ((b >> ((base + k) * nw)) & nmask) << ((2 * k + 1) * nw);
      end
    end
    return r;
  endfunction

  task automatic compare(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Check the previous result, then apply a new operation.
  task automatic step(logic [1:0] o, logic s, logic [63:0] a, logic [63:0] b, string tag);
    @(negedge clk);
    if (exp_q.size() > 0) compare(tag_q.pop_front(), result, exp_q.pop_front());
    op = o; sz = s; src_a = a; src_b = b;
    exp_q.push_back(model(o, s, a, b));
    tag_q.push_back(tag);
  endtask

  function automatic string tag_of(logic [1:0] o, logic s);
    string t;
    case (o)
      2'b00: t = "R3";
      2'b01: t = "R4";
      2'b10: t = "R7";
      default: t = "R6";
    endcase
    return s ? {t, "/R8"} : t;
  endfunction

  initial begin
    rst_n = 1'b0; op = 2'b11; sz = 1'b0;
    src_a = 64'hDEAD_BEEF_0123_4567; src_b = 64'hFFFF_0000_8080_7F7F;
    repeat (2) @(negedge clk);
    compare("R2 reset", result, 64'h0);
    @(posedge clk); #3;
    compare("R2 reset held across edge", result, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R3: upper clamp, lower clamp and copy in one word, both operands
    step(2'b00, 1'b0, 64'h007F_0080_FF80_FF7F, 64'h1234_FFFF_0000_8000, "R3 mixed clamp");
    // R4: negative, above max, exact max, mid
    step(2'b01, 1'b0, 64'hFFFF_0100_00FF_0042, 64'h8000_7FFF_0000_00FE, "R4 unsigned clamp");
    // R8/R3: 32-bit to 16-bit signed
    step(2'b00, 1'b1, 64'h0000_7FFF_0000_8000, 64'hFFFF_8000_FFFF_7FFF, "R8 R3 wide signed");
    // R8/R4: 32-bit to 16-bit unsigned
    step(2'b01, 1'b1, 64'h0001_0000_0000_FFFF, 64'h8000_0000_0000_1234, "R8 R4 wide unsigned");
    // R5: distinct in-range lanes to show placement
    step(2'b00, 1'b0, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, "R5 placement");
    step(2'b01, 1'b1, 64'h0000_2222_0000_1111, 64'h0000_4444_0000_3333, "R5 R8 placement wide");
    // R6/R7 both sizes
    step(2'b11, 1'b0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, "R6 low bytes");
    step(2'b10, 1'b0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, "R7 high bytes");
    step(2'b11, 1'b1, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, "R6 R8 low halfwords");
    step(2'b10, 1'b1, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0, "R7 R8 high halfwords");
    // R1: back-to-back change of op and size every cycle
    step(2'b00, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h0, "R1 back-to-back a");
    step(2'b11, 1'b0, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, "R1 back-to-back b");
    step(2'b01, 1'b0, 64'hFF00_00FF_0100_7FFF, 64'hFFFF_FFFF_FFFF_FFFF, "R1 back-to-back c");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] o;
      logic s;
      o = 2'($urandom);
      s = 1'($urandom);
      step(o, s, {$urandom, $urandom}, {$urandom, $urandom}, tag_of(o, s));
    end
    @(negedge clk);
    if (exp_q.size() > 0) compare(tag_q.pop_front(), result, exp_q.pop_front());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule